// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Unit

This block sits beside a two-port shared memory and turns accesses to two reserved words into an active-low interrupt flag for each port. The highest word address is the right port's mailbox. The word just below it is the left port's mailbox. The message itself stays in the shared array. This unit only watches the access controls of both ports and keeps two pending flags.

A port posts a message by writing into the other port's mailbox. That raises the other port's interrupt. The owner acknowledges by reading its own mailbox, which drops its interrupt. A port that reads the other side's mailbox leaves that side's flag alone. When a port's incoming busy flag is active, its accesses neither post nor acknowledge. The block runs on a single clock. An asynchronous active-low reset is released through a two-stage synchronizer.

Top module: `mbx_irq_unit`

## Requirements
- R1: While reset is asserted, and after it is released with no access, both interrupt outputs are high (no message pending). Reset takes effect without waiting for a clock edge.
- R2: A sampled left write to the address with all bits set raises the right interrupt. A write is chip enable low with read/write low and busy high. The right interrupt goes low on the clock edge that samples the write.
- R3: A sampled right write to the address with all bits set except bit 0 (all ones minus one) drives the left interrupt low on the same edge.
- R4: A read by a port of its own mailbox, with busy high, returns that port's interrupt to high. A read is chip enable low, read/write high and output enable low.
- R5: A read by a port of the other port's mailbox leaves the other port's interrupt unchanged.
- R6: A write to the other port's mailbox while the writer's busy input is low does not raise the interrupt.
- R7: A read of a port's own mailbox while that port's busy input is low does not clear its interrupt.
- R8: With chip enable low and read/write high but output enable high, an access to the own mailbox does not clear the interrupt.
- R9: If a post and an acknowledge for the same flag arrive in the same cycle, the flag ends up pending (output low).
- R10: Writes to any non-mailbox address, writes by a port to its own mailbox, and writes with chip enable high change neither interrupt.
- R11: With no qualifying access, both interrupt outputs hold their value from cycle to cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_cs_n | input | 1 | Left chip enable, active low |
| l_rd_wr | input | 1 | Left read (1) / write (0) |
| l_oe_n | input | 1 | Left output enable, active low |
| l_busy_n | input | 1 | Left busy flag in, active low |
| l_addr | input | ADDR_W | Left word address |
| r_cs_n | input | 1 | Right chip enable, active low |
| r_rd_wr | input | 1 | Right read (1) / write (0) |
| r_oe_n | input | 1 | Right output enable, active low |
| r_busy_n | input | 1 | Right busy flag in, active low |
| r_addr | input | ADDR_W | Right word address |
| l_irq_n | output | 1 | Left interrupt, active low |
| r_irq_n | output | 1 | Right interrupt, active low |

## Verification
The bench builds the unit with ADDR_W set to 4. The two mailboxes then sit at words 15 and 14, and a plain neighbour such as word 13 is only one step away. With this width, every access kind can be driven with short literal vectors: posting, foreign reads, output-enable-less reads, busy-blocked accesses and same-cycle post/acknowledge collisions. Reset is also checked while a flag is pending, and the other outputs are confirmed to stay high afterwards.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
package mbx_pkg;
  typedef enum logic [0:0] {SIDE_L = 1'b0, SIDE_R = 1'b1} side_e;

  typedef struct packed {
    logic post_other;  // qualified write into the opposite mailbox
    logic ack_own;     // qualified read of the own mailbox
  } evt_t;
endpackage

// File: rtl/mbx_rst_sync.sv
`timescale 1ns/1ps
module mbx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sn = stage_q[1];
endmodule

// File: rtl/mbx_port_decode.sv
`timescale 1ns/1ps
module mbx_port_decode #(
  parameter int ADDR_W = 16,
  parameter mbx_pkg::side_e OWN_SIDE = mbx_pkg::SIDE_L
) (
  input  logic              cs_n,
  input  logic              rd_wr,
  input  logic              oe_n,
  input  logic              busy_n,
  input  logic [ADDR_W-1:0] addr,
  output mbx_pkg::evt_t     evt
);
  localparam logic OWN_LSB = (OWN_SIDE == mbx_pkg::SIDE_R);
  localparam logic [ADDR_W-1:0] OWN_BOX   = {{(ADDR_W-1){1'b1}}, OWN_LSB};
  localparam logic [ADDR_W-1:0] OTHER_BOX = {{(ADDR_W-1){1'b1}}, ~OWN_LSB};

  logic wr_stb, rd_stb;

  always_comb begin
    wr_stb = !cs_n && !rd_wr;
    rd_stb = !cs_n && rd_wr && !oe_n;
    evt.post_other = wr_stb && busy_n && (addr == OTHER_BOX);
    evt.ack_own    = rd_stb && busy_n && (addr == OWN_BOX);
  end
endmodule

// File: rtl/mbx_flag.sv
`timescale 1ns/1ps
module mbx_flag (
  input  logic clk,
  input  logic rst_sn,
  input  logic set,
  input  logic clr,
  output logic pend
);
  logic pend_q, pend_d, pend_en;

  always_comb begin
    pend_en = set | clr;
    pend_d  = set ? 1'b1 : 1'b0;  // post wins over acknowledge
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)      pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_d;
  end

  assign pend = pend_q;
endmodule

// File: rtl/mbx_irq_unit.sv
`timescale 1ns/1ps
module mbx_irq_unit #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_cs_n,
  input  logic              l_rd_wr,
  input  logic              l_oe_n,
  input  logic              l_busy_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              r_cs_n,
  input  logic              r_rd_wr,
  input  logic              r_oe_n,
  input  logic              r_busy_n,
  input  logic [ADDR_W-1:0] r_addr,
  output logic              l_irq_n,
  output logic              r_irq_n
);
  localparam int NPORT = 2;

  logic rst_sn;
  logic [NPORT-1:0] cs_v, rw_v, oe_v, busy_v, pend_v;
  logic [ADDR_W-1:0] addr_v [NPORT];
  mbx_pkg::evt_t evt_v [NPORT];

  assign cs_v   = {r_cs_n,   l_cs_n};
  assign rw_v   = {r_rd_wr,  l_rd_wr};
  assign oe_v   = {r_oe_n,   l_oe_n};
  assign busy_v = {r_busy_n, l_busy_n};
  assign addr_v[0] = l_addr;
  assign addr_v[1] = r_addr;

  mbx_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sn(rst_sn));

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    mbx_port_decode #(
      .ADDR_W  (ADDR_W),
      .OWN_SIDE((g == 0) ? mbx_pkg::SIDE_L : mbx_pkg::SIDE_R)
    ) u_dec (
      .cs_n  (cs_v[g]),
      .rd_wr (rw_v[g]),
      .oe_n  (oe_v[g]),
      .busy_n(busy_v[g]),
      .addr  (addr_v[g]),
      .evt   (evt_v[g])
    );

    mbx_flag u_flag (
      .clk   (clk),
      .rst_sn(rst_sn),
      .set   (evt_v[NPORT-1-g].post_other),
      .clr   (evt_v[g].ack_own),
      .pend  (pend_v[g])
    );
  end

  assign l_irq_n = ~pend_v[0];
  assign r_irq_n = ~pend_v[1];
endmodule

// File: rtl/mbx_irq_chk.sv
`timescale 1ns/1ps
module mbx_irq_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_sn,
  input logic              l_cs_n,
  input logic              l_rd_wr,
  input logic              l_oe_n,
  input logic              l_busy_n,
  input logic [ADDR_W-1:0] l_addr,
  input logic              r_cs_n,
  input logic              r_rd_wr,
  input logic              r_oe_n,
  input logic              r_busy_n,
  input logic [ADDR_W-1:0] r_addr,
  input logic              l_irq_n,
  input logic              r_irq_n
);
  localparam logic [ADDR_W-1:0] BOX_R = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] BOX_L = {{(ADDR_W-1){1'b1}}, 1'b0};

  logic l_post, r_post, l_ack, r_ack;
  assign l_post = !l_cs_n && !l_rd_wr && l_busy_n && (l_addr == BOX_R);
  assign r_post = !r_cs_n && !r_rd_wr && r_busy_n && (r_addr == BOX_L);
  assign l_ack  = !l_cs_n && l_rd_wr && !l_oe_n && l_busy_n && (l_addr == BOX_L);
  assign r_ack  = !r_cs_n && r_rd_wr && !r_oe_n && r_busy_n && (r_addr == BOX_R);

  // R2 R9
  left_post_raises_right_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    l_post |=> !r_irq_n);

  // R3 R9
  right_post_raises_left_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    r_post |=> !l_irq_n);

  // R6 R10
  right_irq_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    $fell(r_irq_n) |-> $past(l_post));

  // R6 R10
  left_irq_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    $fell(l_irq_n) |-> $past(r_post));

  // R5 R7 R8
  right_irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(r_irq_n) |-> $past(r_ack));

  // R5 R7 R8
  left_irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(l_irq_n) |-> $past(l_ack));
endmodule

bind mbx_irq_unit mbx_irq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_sn(rst_sn),
  .l_cs_n(l_cs_n), .l_rd_wr(l_rd_wr), .l_oe_n(l_oe_n), .l_busy_n(l_busy_n), .l_addr(l_addr),
  .r_cs_n(r_cs_n), .r_rd_wr(r_rd_wr), .r_oe_n(r_oe_n), .r_busy_n(r_busy_n), .r_addr(r_addr),
  .l_irq_n(l_irq_n), .r_irq_n(r_irq_n)
);

// File: tb/sim_mbx_irq_unit.sv
`timescale 1ns/1ps
module sim_mbx_irq_unit;
  localparam int AW = 4;
  localparam int NV = 20;

  logic clk = 1'b0;
  logic rst_n;
  logic l_cs_n, l_rd_wr, l_oe_n, l_busy_n, r_cs_n, r_rd_wr, r_oe_n, r_busy_n;
  logic [AW-1:0] l_addr, r_addr;
  logic l_irq_n, r_irq_n;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mbx_irq_unit #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .l_cs_n(l_cs_n), .l_rd_wr(l_rd_wr), .l_oe_n(l_oe_n), .l_busy_n(l_busy_n), .l_addr(l_addr),
    .r_cs_n(r_cs_n), .r_rd_wr(r_rd_wr), .r_oe_n(r_oe_n), .r_busy_n(r_busy_n), .r_addr(r_addr),
    .l_irq_n(l_irq_n), .r_irq_n(r_irq_n)
  );

  // port byte = {cs_n, rd_wr, oe_n, busy_n, addr[3:0]}
  // F0 idle, 3x write, 5x read, 2x busy write, 4x busy read, 7x read without oe
  // entry = {left, right, exp l_irq_n, exp r_irq_n, requirement}
  localparam logic [21:0] VEC [NV] = '{
    {8'hF0, 8'hF0, 2'b11, 4'd11}, // R11 quiet
    {8'h3F, 8'hF0, 2'b10, 4'd2},  // R2 left posts right
    {8'hF0, 8'hF0, 2'b10, 4'd11}, // R11 hold
    {8'h5F, 8'hF0, 2'b10, 4'd5},  // R5 foreign read
    {8'hF0, 8'h7F, 2'b10, 4'd8},  // R8 no output enable
    {8'hF0, 8'h4F, 2'b10, 4'd7},  // R7 busy read
    {8'hF0, 8'h5F, 2'b11, 4'd4},  // R4 right acknowledges
    {8'h2F, 8'hF0, 2'b11, 4'd6},  // R6 busy write
    {8'hF0, 8'h3E, 2'b01, 4'd3},  // R3 right posts left
    {8'hF0, 8'h5E, 2'b01, 4'd5},  // R5 foreign read
    {8'h3E, 8'hF0, 2'b01, 4'd10}, // R10 write own mailbox
    {8'h5E, 8'hF0, 2'b11, 4'd4},  // R4 left acknowledges
    {8'h3D, 8'h3D, 2'b11, 4'd10}, // R10 plain address
    {8'hF0, 8'h2E, 2'b11, 4'd6},  // R6 busy write
    {8'hF0, 8'h3E, 2'b01, 4'd3},  // R3
    {8'h4E, 8'hF0, 2'b01, 4'd7},  // R7 busy read
    {8'h3F, 8'h5F, 2'b00, 4'd9},  // R9 post and ack right
    {8'h5E, 8'h3E, 2'b00, 4'd9},  // R9 post and ack left
    {8'h5E, 8'h5F, 2'b11, 4'd4},  // R4 both acknowledge
    {8'hBF, 8'hBE, 2'b11, 4'd10}  // R10 chip enable high
  };

  task automatic drive(input logic [7:0] lp, input logic [7:0] rp);
    {l_cs_n, l_rd_wr, l_oe_n, l_busy_n, l_addr} = lp;
    {r_cs_n, r_rd_wr, r_oe_n, r_busy_n, r_addr} = rp;
  endtask

  task automatic check(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", what, act, exp);
    end
  endtask

  initial begin
    rst_n = 1'b1;
    drive(8'hF0, 8'hF0);
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(l_irq_n, 1'b1, "R1 left during reset");
    check(r_irq_n, 1'b1, "R1 right during reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(l_irq_n, 1'b1, "R1 left after release");
    check(r_irq_n, 1'b1, "R1 right after release");

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][21:14], VEC[i][13:6]);
      @(negedge clk);
      check(l_irq_n, VEC[i][5], $sformatf("R%0d vec %0d left", VEC[i][3:0], i));
      check(r_irq_n, VEC[i][4], $sformatf("R%0d vec %0d right", VEC[i][3:0], i));
    end

    // R1: reset while both flags pending
    drive(8'h3F, 8'h3E);
    @(negedge clk);
    check(r_irq_n, 1'b0, "R2 pre-reset post");
    check(l_irq_n, 1'b0, "R3 pre-reset post");
    drive(8'hF0, 8'hF0);
    #0.5 rst_n = 1'b0;
    #0.5;
    check(l_irq_n, 1'b1, "R1 left async clear");
    check(r_irq_n, 1'b1, "R1 right async clear");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(l_irq_n, 1'b1, "R1 left stays idle");
    check(r_irq_n, 1'b1, "R1 right stays idle");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired R11");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule